// File: doc/BRIEF.md
# SDRAM Read Burst Splitter

This block converts one linear, incrementing read request from a local bus into the series of SDRAM column read commands that serves it. A request carries a start column, a length in columns and the index of the target device. The SDRAM always transfers data in bursts, and each data phase carries two adjacent columns. For this reason one local request can need several commands. These are a short 4-column (chopped) burst to reach 4-column alignment or 8-column alignment, then full 8-column bursts at 8-column boundaries. The last full burst may run past the end of the request.

Each command leaves on a valid/ready port with its column, its burst kind and an active-low select for the addressed device. A small tag queue records, for every issued command, which of its returning data phases belong to the request. Downstream logic strobes each returning data phase in and receives a per-phase keep flag. The surplus phases are then free for reuse by other traffic.

Top module: `sdram_rd_splitter`

## Requirements
- R1: After reset, req_ready is 1, cmd_valid is 0 and every cmd_cs_n line is 1.
- R2: Bit 0 of req_col and bit 0 of req_len are ignored (treated as 0). Lengths are even and lie in 2..64 columns.
- R3: A command at a column c with c mod 4 = 2 is chopped (cmd_chop=1). It advances c by 2. Of its two data phases the first is kept and the second is unused.
- R4: A command at a column c with c mod 8 = 4 is chopped and advances c by 4. Both phases are kept when at least 4 columns remain; otherwise only the first is kept.
- R5: A command at a column that is a multiple of 8 is a full burst (cmd_chop=0) with four data phases and advances by 8. With r columns remaining, the first min(4, r/2) phases are kept and the rest are unused.
- R6: Commands follow the column order of R3 to R5, wrapping modulo 2^COL_W. The last command is the one whose advance covers the remaining length. For example, 16 columns from column 2 give commands at 2, 4, 8 and 16.
- R7: While cmd_valid is 1, exactly the cmd_cs_n bit of the request's device is 0. While cmd_valid is 0, all bits are 1.
- R8: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_col and cmd_chop hold their values into the next cycle.
- R9: req_ready is 0 from the cycle after a request is accepted until the cycle after its last command is accepted.
- R10: Each dq_beat strobe consumes the next data phase in command issue order (2 phases per chopped command, 4 per full one). beat_keep is 1 only on a dq_beat cycle whose phase is kept.
- R11: At most TAG_DEPTH (default 8) issued commands can have phases still outstanding. Past that point cmd_valid stays 0 until phases return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_col | input | COL_W | Start column |
| req_len | input | LEN_W | Length in columns |
| req_dev | input | DEV_W | Target device index |
| cmd_valid | output | 1 | Column read command present |
| cmd_ready | input | 1 | Command taken downstream |
| cmd_col | output | COL_W | Start column of the command |
| cmd_chop | output | 1 | 1 = chopped 4-column burst, 0 = full 8-column burst |
| cmd_cs_n | output | NUM_CS | Active-low device selects |
| dq_beat | input | 1 | One returning data phase this cycle |
| beat_keep | output | 1 | Current data phase belongs to the request |

## Verification
On every cycle the assertions check four things: commands hold steady under backpressure, full bursts sit on 8-column boundaries, at most one select is low and none is low without a command, and the tag queue never overflows or underflows. The exact command sequence for each start alignment, the keep/unused pattern of the returning phases, and the release of req_ready can only be shown by the bench's scenarios. The same holds for the stall once eight commands are outstanding and for column wrap. The bench compares these against a model of the splitting rules.

// File: rtl/sdram_rd_split_pkg.sv
package sdram_rd_split_pkg;

   localparam int PHASES_FULL = 4;
   localparam int PHASES_CHOP = 2;

   typedef struct packed {
      logic       chop;
      logic [3:0] keep;
   } beat_tag_t;

   localparam int TAG_W = $bits(beat_tag_t);

endpackage

// File: rtl/rd_split_seq.sv
module rd_split_seq
   import sdram_rd_split_pkg::*;
#(
   parameter int COL_W = 10,
   parameter int LEN_W = 7,
   parameter int DEV_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [COL_W-1:0] req_col,
   input  logic [LEN_W-1:0] req_len,
   input  logic [DEV_W-1:0] req_dev,
   input  logic             room,
   input  logic             cmd_ready,
   output logic             cmd_valid,
   output logic [COL_W-1:0] cmd_col,
   output logic             cmd_chop,
   output logic [DEV_W-1:0] cmd_dev,
   output beat_tag_t        cmd_tag,
   output logic             cmd_fire
);

   logic             busy_q;
   logic [COL_W-1:0] col_q;
   logic [LEN_W-1:0] rem_q;
   logic [DEV_W-1:0] dev_q;

   logic [LEN_W-1:0] adv;
   logic [2:0]       pairs;
   logic             chop;
   logic             last;

   always_comb begin
      if (col_q[1]) begin
         chop  = 1'b1;
         adv   = LEN_W'(2);
         pairs = 3'd1;
      end else if (col_q[2]) begin
         chop  = 1'b1;
         adv   = LEN_W'(4);
         pairs = (rem_q >= LEN_W'(4)) ? 3'd2 : 3'd1;
      end else begin
         chop  = 1'b0;
         adv   = LEN_W'(8);
         pairs = (rem_q >= LEN_W'(8)) ? 3'd4 : 3'(rem_q[3:1]);
      end
      last = (rem_q <= adv);
      cmd_tag.chop = chop;
      for (int k = 0; k < 4; k++) begin
         cmd_tag.keep[k] = (3'(k) < pairs);
      end
   end

   assign req_ready = !busy_q;
   assign cmd_valid = busy_q && room;
   assign cmd_col   = col_q;
   assign cmd_chop  = chop;
   assign cmd_dev   = dev_q;
   assign cmd_fire  = cmd_valid && cmd_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         col_q  <= '0;
         rem_q  <= '0;
         dev_q  <= '0;
      end else if (!busy_q) begin
         if (req_valid) begin
            busy_q <= 1'b1;
            col_q  <= {req_col[COL_W-1:1], 1'b0};
            rem_q  <= {req_len[LEN_W-1:1], 1'b0};
            dev_q  <= req_dev;
         end
      end else if (cmd_fire) begin
         col_q <= col_q + COL_W'(adv);
         rem_q <= last ? '0 : rem_q - adv;
         if (last) busy_q <= 1'b0;
      end
   end

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_col) && $stable(cmd_chop));

   a_r5_full_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cmd_chop |-> cmd_col[2:0] == 3'd0);

   a_r3_odd_pair_chops: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_col[1] |-> cmd_chop && (cmd_tag.keep == 4'b0001));

endmodule

// File: rtl/rd_tag_fifo.sv
module rd_tag_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);

   localparam int AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_q, rd_q;
   logic [AW:0]      cnt_q;

   assign full  = (cnt_q == (AW+1)'(DEPTH));
   assign empty = (cnt_q == '0);
   assign dout  = mem[rd_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + (AW+1)'(push) - (AW+1)'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_q] <= din;
   end

   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full || pop);

   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/rd_beat_mark.sv
module rd_beat_mark
   import sdram_rd_split_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      dq_beat,
   input  beat_tag_t head,
   input  logic      empty,
   output logic      beat_keep,
   output logic      pop
);

   logic [1:0] idx_q;
   logic       last_phase;
   logic       take;

   assign take       = dq_beat && !empty;
   assign last_phase = head.chop ? (idx_q == 2'(PHASES_CHOP - 1))
                                 : (idx_q == 2'(PHASES_FULL - 1));
   assign pop        = take && last_phase;
   assign beat_keep  = take && head.keep[idx_q];

   always_ff @(posedge clk) begin
      if (!rst_n)    idx_q <= '0;
      else if (pop)  idx_q <= '0;
      else if (take) idx_q <= idx_q + 1'b1;
   end

   a_r10_keep_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
      beat_keep |-> dq_beat);

endmodule

// File: rtl/sdram_rd_splitter.sv
module sdram_rd_splitter
   import sdram_rd_split_pkg::*;
#(
   parameter int COL_W     = 10,
   parameter int LEN_W     = 7,
   parameter int NUM_CS    = 2,
   parameter int TAG_DEPTH = 8,
   localparam int DEV_W    = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [COL_W-1:0]  req_col,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DEV_W-1:0]  req_dev,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [COL_W-1:0]  cmd_col,
   output logic              cmd_chop,
   output logic [NUM_CS-1:0] cmd_cs_n,
   input  logic              dq_beat,
   output logic              beat_keep
);

   if (COL_W < 4) begin : g_bad_col
      $error("COL_W must be at least 4");
   end
   if (LEN_W < 4) begin : g_bad_len
      $error("LEN_W must be at least 4");
   end
   if (NUM_CS < 1) begin : g_bad_cs
      $error("NUM_CS must be at least 1");
   end
   if (TAG_DEPTH < 2 || (TAG_DEPTH & (TAG_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("TAG_DEPTH must be a power of two, at least 2");
   end

   beat_tag_t        new_tag, head_tag;
   logic [DEV_W-1:0] cmd_dev;
   logic             fire, tag_full, tag_empty, tag_pop;

   rd_split_seq #(.COL_W(COL_W), .LEN_W(LEN_W), .DEV_W(DEV_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .req_col   (req_col),
      .req_len   (req_len),
      .req_dev   (req_dev),
      .room      (!tag_full),
      .cmd_ready (cmd_ready),
      .cmd_valid (cmd_valid),
      .cmd_col   (cmd_col),
      .cmd_chop  (cmd_chop),
      .cmd_dev   (cmd_dev),
      .cmd_tag   (new_tag),
      .cmd_fire  (fire)
   );

   rd_tag_fifo #(.DEPTH(TAG_DEPTH), .WIDTH(TAG_W)) u_tags (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fire),
      .din   (new_tag),
      .pop   (tag_pop),
      .dout  (head_tag),
      .full  (tag_full),
      .empty (tag_empty)
   );

   rd_beat_mark u_mark (
      .clk       (clk),
      .rst_n     (rst_n),
      .dq_beat   (dq_beat),
      .head      (head_tag),
      .empty     (tag_empty),
      .beat_keep (beat_keep),
      .pop       (tag_pop)
   );

   if (NUM_CS == 1) begin : g_cs_single
      assign cmd_cs_n[0] = !cmd_valid;
   end else begin : g_cs_multi
      for (genvar g = 0; g < NUM_CS; g++) begin : g_dev
         assign cmd_cs_n[g] = !(cmd_valid && (cmd_dev == DEV_W'(g)));
      end
   end

   a_r7_one_select: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $countones(~cmd_cs_n) == 1);

   a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> &cmd_cs_n);

endmodule

// File: tb/sdram_rd_splitter_tb.sv
module sdram_rd_splitter_tb;

   localparam int COL_W  = 10;
   localparam int LEN_W  = 7;
   localparam int NUM_CS = 2;
   localparam int DEV_W  = 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic              req_ready;
   logic [COL_W-1:0]  req_col = '0;
   logic [LEN_W-1:0]  req_len = '0;
   logic [DEV_W-1:0]  req_dev = '0;
   logic              cmd_valid;
   logic              cmd_ready = 1'b0;
   logic [COL_W-1:0]  cmd_col;
   logic              cmd_chop;
   logic [NUM_CS-1:0] cmd_cs_n;
   logic              dq_beat = 1'b0;
   logic              beat_keep;

   always #5 clk = ~clk;

   sdram_rd_splitter #(.COL_W(COL_W), .LEN_W(LEN_W), .NUM_CS(NUM_CS), .TAG_DEPTH(8)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_col(req_col), .req_len(req_len), .req_dev(req_dev),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_col(cmd_col),
      .cmd_chop(cmd_chop), .cmd_cs_n(cmd_cs_n),
      .dq_beat(dq_beat), .beat_keep(beat_keep)
   );

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   int hs_count = 0;
   bit beats_en = 1'b1;
   bit force_ready = 1'b0;

   int exp_col[$];
   bit exp_chop[$];
   int exp_dev[$];
   int exp_pairs[$];
   int exp_req[$];
   bit exp_beat[$];

   bit prev_stall = 1'b0;
   int prev_col = 0;
   bit prev_chop = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Model of the splitting rules (R2..R6)
   task automatic model_request(input int col, input int len, input int dev);
      int  c, r, adv, pairs, tag;
      bit  ch, last;
      c = col & ((1 << COL_W) - 2);
      r = len & ((1 << LEN_W) - 2);
      do begin
         if ((c % 4) == 2) begin
            ch = 1; adv = 2; pairs = 1; tag = 3;
         end else if ((c % 8) == 4) begin
            ch = 1; adv = 4; pairs = (r >= 4) ? 2 : 1; tag = 4;
         end else begin
            ch = 0; adv = 8; pairs = (r >= 8) ? 4 : r / 2; tag = 5;
         end
         exp_col.push_back(c);
         exp_chop.push_back(ch);
         exp_dev.push_back(dev);
         exp_pairs.push_back(pairs);
         exp_req.push_back(tag);
         last = (r <= adv);
         c = (c + adv) % (1 << COL_W);
         r = r - adv;
      end while (!last);
   endtask

   // Input drivers, away from the active edge
   always @(posedge clk) begin
      #1;
      cmd_ready = force_ready ? 1'b1 : (($urandom % 100) < 70);
      dq_beat   = beats_en && (exp_beat.size() > 0) && (($urandom % 100) < 60);
   end

   // Output monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (cmd_valid) begin
            chk(req_ready == 1'b0, "R9", "req_ready while command pending", req_ready, 0);
         end
         if (prev_stall) begin
            chk(cmd_valid && cmd_col == COL_W'(prev_col) && cmd_chop == prev_chop,
                "R8", "command held under backpressure", int'(cmd_col), prev_col);
         end
         prev_stall = cmd_valid && !cmd_ready;
         prev_col   = int'(cmd_col);
         prev_chop  = cmd_chop;

         if (!cmd_valid) begin
            chk(&cmd_cs_n, "R7", "selects idle", int'(cmd_cs_n), (1 << NUM_CS) - 1);
         end else if (exp_col.size() == 0) begin
            chk(1'b0, "R6", "unexpected command column", int'(cmd_col), -1);
         end else begin
            chk(cmd_cs_n == NUM_CS'(~(1 << exp_dev[0])), "R7", "device select",
                int'(cmd_cs_n), int'(NUM_CS'(~(1 << exp_dev[0]))));
            if (cmd_ready) begin
               string rt;
               int p;
               rt = (exp_req[0] == 3) ? "R3" : (exp_req[0] == 4) ? "R4" : "R5";
               chk(cmd_col == COL_W'(exp_col[0]), "R6", "command column",
                   int'(cmd_col), exp_col[0]);
               chk(cmd_chop == exp_chop[0], rt, "burst kind", cmd_chop, exp_chop[0]);
               p = exp_pairs[0];
               for (int k = 0; k < (exp_chop[0] ? 2 : 4); k++) begin
                  exp_beat.push_back(k < p);
               end
               void'(exp_col.pop_front());
               void'(exp_chop.pop_front());
               void'(exp_dev.pop_front());
               void'(exp_pairs.pop_front());
               void'(exp_req.pop_front());
               hs_count++;
            end
         end

         if (dq_beat) begin
            if (exp_beat.size() == 0) begin
               chk(1'b0, "R10", "beat with nothing outstanding", beat_keep, 0);
            end else begin
               chk(beat_keep == exp_beat[0], "R10", "phase keep flag",
                   beat_keep, exp_beat[0]);
               void'(exp_beat.pop_front());
            end
         end else begin
            chk(beat_keep == 1'b0, "R10", "keep without beat", beat_keep, 0);
         end
      end
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL R6 watchdog: cycles=%0d expected=%0d", cycles, 150000);
         finish_run();
      end
   end

   task automatic send_req(input int col, input int len, input int dev);
      @(posedge clk);
      #1;
      req_valid = 1'b1;
      req_col   = COL_W'(col);
      req_len   = LEN_W'(len);
      req_dev   = DEV_W'(dev);
      do @(negedge clk); while (!req_ready);
      model_request(col, len, dev);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      @(negedge clk);
      chk(req_ready == 1'b0, "R9", "req_ready after accept", req_ready, 0);
   endtask

   task automatic drain();
      while (exp_col.size() != 0 || exp_beat.size() != 0) @(negedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R9", "req_ready after last command", req_ready, 1);
   endtask

   initial begin
      int base;
      void'($urandom(32'h5EED_0042));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
      chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
      chk(&cmd_cs_n, "R1", "reset selects", int'(cmd_cs_n), (1 << NUM_CS) - 1);

      // Directed: alignment cases for a 16-column request (R3, R4, R5, R6)
      send_req(0, 16, 0);  drain();
      send_req(2, 16, 1);  drain();
      send_req(4, 16, 0);  drain();
      send_req(6, 16, 1);  drain();
      // Short requests ending inside the lead-in (R3, R4)
      send_req(2, 2, 0);   drain();
      send_req(4, 2, 1);   drain();
      send_req(8, 6, 0);   drain();
      // R2: odd column and odd length treated as even
      send_req(5, 9, 1);   drain();
      // Column wrap (R6)
      send_req(1020, 16, 0); drain();
      send_req(0, 64, 1);  drain();

      // R11: stall after TAG_DEPTH outstanding commands (10 commands in total)
      beats_en = 1'b0;
      force_ready = 1'b1;
      base = hs_count;
      send_req(2, 64, 0);
      repeat (30) @(negedge clk);
      chk(hs_count - base == 8, "R11", "commands issued with no beats back",
          hs_count - base, 8);
      chk(cmd_valid == 1'b0, "R11", "cmd_valid while tags full", cmd_valid, 0);
      beats_en = 1'b1;
      force_ready = 1'b0;
      drain();

      // Constrained random
      for (int i = 0; i < 250; i++) begin
         send_req($urandom % (1 << COL_W), 1 + ($urandom % 64), $urandom % NUM_CS);
         if (($urandom % 4) == 0) drain();
      end
      drain();
      chk(exp_col.size() == 0 && cmd_valid == 1'b0, "R6", "no extra commands",
          int'(cmd_valid), 0);
      finish_run();
   end

endmodule